// File: doc/BRIEF.md
# SPI Master Byte Shift Engine

This block is the serial core of an SPI controller operating as bus master. It pulls bytes from a transmit source that shows a valid flag, serialises each byte onto MOSI under a divided serial clock with clock polarity 0 and phase 0, samples MISO on every rising SCLK edge, and hands each received byte to the rest of the controller with a one-cycle strobe. It also sequences frames: it holds the active-low slave select across a burst of bytes in continuous mode, or frames every byte separately with a fixed pause of one SCLK period between them.

A transfer can also be requested with no transmit data waiting. The outgoing byte is then either all zeros or a repeat of the last byte sent, chosen by a configuration input. A loopback mode feeds MOSI back to the receive side in place of the MISO pin. A separate control gates the slave-mode MISO driver, turning it into a released, open-drain style output.

Top module: `spi_shift_master`

## Requirements
- R1: After reset `ss_n` is 1, `sclk` is 0, `rx_done` is 0 and `tx_pop` is 0.
- R2: With `cfg_lsb_first` = 0, bit 7 of a byte is driven on MOSI first, and the first bit sampled from MISO lands in bit 7 of `rx_data`.
- R3: With `cfg_lsb_first` = 1, bit 0 is driven first, and the first bit sampled lands in bit 0 of `rx_data`.
- R4: SCLK idles low while `ss_n` is high; each SCLK high phase and each low phase inside a frame lasts `sclk_half`+1 clock cycles; MISO is sampled on the rising SCLK edge.
- R5: Each byte produces exactly one single-cycle `rx_done` pulse carrying the received byte, and `tx_pop` is high for one cycle per byte taken from a valid source.
- R6: With `cfg_cont` = 1, `ss_n` stays low across consecutive bytes and rises only after a byte ends with neither `tx_valid` nor `fill_req` high.
- R7: With `cfg_cont` = 0, `ss_n` rises after every byte and, when more work is pending, stays high for exactly 2*(`sclk_half`+1) cycles before the next byte starts.
- R8: When a byte starts with `tx_valid` low because `fill_req` is high and `cfg_zero_fill` = 1, the byte sent is 0x00.
- R9: With `cfg_zero_fill` = 0 such a byte repeats the last byte sent (including an earlier fill byte); after reset that last byte is 0x00.
- R10: With `cfg_loopback` = 1 the received byte equals the transmitted byte regardless of the MISO pin.
- R11: With `cfg_miso_dis` = 1, `slv_miso_oe` is 0 and `slv_miso_o` is 0; with it 0, `slv_miso_oe` is 1 and `slv_miso_o` follows `slv_bit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_half | input | DIV_W | SCLK half period minus one, in clock cycles |
| cfg_cont | input | 1 | Hold slave select across back-to-back bytes |
| cfg_lsb_first | input | 1 | Shift bit 0 first |
| cfg_zero_fill | input | 1 | Fill byte is 0x00 (else repeat last byte) |
| cfg_loopback | input | 1 | Receive from MOSI instead of MISO |
| cfg_miso_dis | input | 1 | Release the slave-mode MISO driver |
| tx_data | input | DATA_W | Byte offered by the transmit source |
| tx_valid | input | 1 | Transmit source holds a byte |
| fill_req | input | 1 | Run a transfer even without transmit data |
| tx_pop | output | 1 | Byte on tx_data is taken this cycle |
| rx_data | output | DATA_W | Last received byte |
| rx_done | output | 1 | One-cycle strobe: rx_data is new |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| ss_n | output | 1 | Active-low slave select |
| miso | input | 1 | Serial data in |
| slv_bit | input | 1 | Bit a slave-mode shifter wants on MISO |
| slv_miso_o | output | 1 | Slave-mode MISO data |
| slv_miso_oe | output | 1 | Slave-mode MISO driver enable |

## Verification
The decision at the end of a byte and the draining of the transmit source fall on the same clock edge: in continuous mode the last pop empties the source, so at the final falling SCLK edge the engine sees nothing pending and must release slave select rather than start a phantom byte. The bench provokes this by loading a fixed burst into a source model that drains exactly, and judges it by one slave-select rise for the whole burst and a captured byte count equal to the bytes loaded. A second coincidence, a fill request withdrawn in the cycle slave select falls, is judged by exactly one fill byte appearing on MOSI.

// File: rtl/spi_shift_pkg.sv
package spi_shift_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOW  = 2'd1,
      ST_HIGH = 2'd2,
      ST_GAP  = 2'd3
   } eng_state_t;

   function automatic int unsigned bit_cnt_width(input int unsigned data_w);
      return $clog2(data_w + 1);
   endfunction

endpackage

// File: rtl/spi_sclk_div.sv
module spi_sclk_div #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] half_div,
   output logic             tick
);

   logic [DIV_W-1:0] cnt_q;

   assign tick = run && (cnt_q >= half_div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/spi_bit_path.sv
module spi_bit_path #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              use_tx,
   input  logic [DATA_W-1:0] tx_byte,
   input  logic              zero_fill,
   input  logic              shift,
   input  logic              sample,
   input  logic              capture,
   input  logic              lsb_first,
   input  logic              rx_in,
   output logic              mosi,
   output logic [DATA_W-1:0] rx_byte,
   output logic              rx_done
);

   logic [DATA_W-1:0] sh_q;
   logic [DATA_W-1:0] last_q;
   logic [DATA_W-1:0] rx_sh_q;
   logic [DATA_W-1:0] rx_byte_q;
   logic              rx_done_q;
   logic [DATA_W-1:0] fill_byte;
   logic [DATA_W-1:0] load_byte;
   logic [DATA_W-1:0] sh_next;
   logic [DATA_W-1:0] rx_next;

   assign fill_byte = zero_fill ? '0 : last_q;
   assign load_byte = use_tx ? tx_byte : fill_byte;

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (i == 0) begin : g_low_end
         assign sh_next[i] = lsb_first ? sh_q[i+1]    : 1'b0;
         assign rx_next[i] = lsb_first ? rx_sh_q[i+1] : rx_in;
      end else if (i == DATA_W-1) begin : g_high_end
         assign sh_next[i] = lsb_first ? 1'b0  : sh_q[i-1];
         assign rx_next[i] = lsb_first ? rx_in : rx_sh_q[i-1];
      end else begin : g_middle
         assign sh_next[i] = lsb_first ? sh_q[i+1]    : sh_q[i-1];
         assign rx_next[i] = lsb_first ? rx_sh_q[i+1] : rx_sh_q[i-1];
      end
   end

   assign mosi    = lsb_first ? sh_q[0] : sh_q[DATA_W-1];
   assign rx_byte = rx_byte_q;
   assign rx_done = rx_done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         last_q <= '0;
      end else if (load) begin
         sh_q   <= load_byte;
         last_q <= load_byte;
      end else if (shift) begin
         sh_q   <= sh_next;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_sh_q   <= '0;
         rx_byte_q <= '0;
         rx_done_q <= 1'b0;
      end else begin
         rx_done_q <= capture;
         if (sample) begin
            rx_sh_q <= rx_next;
         end
         if (capture) begin
            rx_byte_q <= rx_next;
         end
      end
   end

endmodule

// File: rtl/spi_frame_ctl.sv
module spi_frame_ctl
   import spi_shift_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic pending,
   input  logic cont,
   output logic run,
   output logic load,
   output logic sample,
   output logic shift,
   output logic capture,
   output logic ss_n,
   output logic sclk
);

   localparam int CNT_W = bit_cnt_width(DATA_W);
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] FINAL_SAMPLE = CNT_W'(DATA_W - 1);

   eng_state_t       state_q;
   logic [CNT_W-1:0] bit_q;
   logic             ss_q;
   logic             sclk_q;
   logic             gap_half_q;
   logic             byte_end;
   logic             start;

   assign byte_end = (bit_q == LAST_CNT);

   always_comb begin
      start = 1'b0;
      case (state_q)
         ST_IDLE: start = pending;
         ST_GAP:  start = tick && gap_half_q && pending;
         ST_HIGH: start = tick && byte_end && cont && pending;
         default: start = 1'b0;
      endcase
   end

   assign run     = (state_q != ST_IDLE);
   assign load    = start;
   assign sample  = (state_q == ST_LOW) && tick;
   assign capture = sample && (bit_q == FINAL_SAMPLE);
   assign shift   = (state_q == ST_HIGH) && tick && !byte_end;
   assign ss_n    = ss_q;
   assign sclk    = sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         bit_q      <= '0;
         ss_q       <= 1'b1;
         sclk_q     <= 1'b0;
         gap_half_q <= 1'b0;
      end else if (start) begin
         state_q    <= ST_LOW;
         bit_q      <= '0;
         ss_q       <= 1'b0;
         sclk_q     <= 1'b0;
         gap_half_q <= 1'b0;
      end else begin
         case (state_q)
            ST_LOW: begin
               if (tick) begin
                  sclk_q  <= 1'b1;
                  bit_q   <= bit_q + 1'b1;
                  state_q <= ST_HIGH;
               end
            end
            ST_HIGH: begin
               if (tick) begin
                  sclk_q <= 1'b0;
                  if (!byte_end) begin
                     state_q <= ST_LOW;
                  end else begin
                     ss_q       <= 1'b1;
                     gap_half_q <= 1'b0;
                     state_q    <= cont ? ST_IDLE : ST_GAP;
                  end
               end
            end
            ST_GAP: begin
               if (tick) begin
                  if (!gap_half_q) begin
                     gap_half_q <= 1'b1;
                  end else begin
                     state_q <= ST_IDLE;
                  end
               end
            end
            default: begin
               state_q <= ST_IDLE;
            end
         endcase
      end
   end

endmodule

// File: rtl/spi_shift_master.sv
module spi_shift_master #(
   parameter int DATA_W = 8,
   parameter int DIV_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  sclk_half,
   input  logic              cfg_cont,
   input  logic              cfg_lsb_first,
   input  logic              cfg_zero_fill,
   input  logic              cfg_loopback,
   input  logic              cfg_miso_dis,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_valid,
   input  logic              fill_req,
   output logic              tx_pop,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_done,
   output logic              sclk,
   output logic              mosi,
   output logic              ss_n,
   input  logic              miso,
   input  logic              slv_bit,
   output logic              slv_miso_o,
   output logic              slv_miso_oe
);

   if (DATA_W < 2) begin : g_bad_data_w
      $error("spi_shift_master: DATA_W must be at least 2");
   end
   if (DIV_W < 1) begin : g_bad_div_w
      $error("spi_shift_master: DIV_W must be at least 1");
   end

   logic tick;
   logic run;
   logic load;
   logic sample;
   logic shift;
   logic capture;
   logic pending;
   logic rx_in;
   logic mosi_int;

   assign pending = tx_valid | fill_req;
   assign rx_in   = cfg_loopback ? mosi_int : miso;
   assign mosi    = mosi_int;
   assign tx_pop  = load & tx_valid;

   spi_sclk_div #(
      .DIV_W (DIV_W)
   ) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .half_div (sclk_half),
      .tick     (tick)
   );

   spi_frame_ctl #(
      .DATA_W (DATA_W)
   ) u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .pending (pending),
      .cont    (cfg_cont),
      .run     (run),
      .load    (load),
      .sample  (sample),
      .shift   (shift),
      .capture (capture),
      .ss_n    (ss_n),
      .sclk    (sclk)
   );

   spi_bit_path #(
      .DATA_W (DATA_W)
   ) u_path (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .use_tx    (tx_valid),
      .tx_byte   (tx_data),
      .zero_fill (cfg_zero_fill),
      .shift     (shift),
      .sample    (sample),
      .capture   (capture),
      .lsb_first (cfg_lsb_first),
      .rx_in     (rx_in),
      .mosi      (mosi_int),
      .rx_byte   (rx_data),
      .rx_done   (rx_done)
   );

   assign slv_miso_oe = ~cfg_miso_dis;
   assign slv_miso_o  = cfg_miso_dis ? 1'b0 : slv_bit;

endmodule

// File: rtl/spi_shift_master_chk.sv
module spi_shift_master_chk #(
   parameter int DATA_W = 8,
   parameter int DIV_W  = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [DIV_W-1:0] sclk_half,
   input logic             cfg_cont,
   input logic             tx_valid,
   input logic             fill_req,
   input logic             tx_pop,
   input logic             rx_done,
   input logic             sclk,
   input logic             ss_n,
   input logic             slv_miso_o,
   input logic             slv_miso_oe
);

   // R4: serial clock rests low outside a frame
   a_r4_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      ss_n |-> !sclk);

   // R4: a high phase lasts at least two cycles when the half period exceeds one
   a_r4_high_width: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sclk) && (sclk_half != '0)) |=> sclk);

   // R5: the byte strobe never lasts two cycles
   a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |=> !rx_done);

   // R5: the byte strobe rises together with the final sampling edge
   a_r5_done_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_done) |-> sclk);

   // R5: a byte is only taken from a valid source
   a_r5_pop_valid: assert property (@(posedge clk) disable iff (!rst_n)
      tx_pop |-> tx_valid);

   // R6: in continuous mode select is only released when nothing was pending
   a_r6_cont_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ss_n) && $past(cfg_cont)) |-> (!$past(tx_valid) && !$past(fill_req)));

   // R11: a released slave driver presents no high level
   a_r11_released_low: assert property (@(posedge clk) disable iff (!rst_n)
      !slv_miso_oe |-> !slv_miso_o);

endmodule

bind spi_shift_master spi_shift_master_chk #(
   .DATA_W (DATA_W),
   .DIV_W  (DIV_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sclk_half   (sclk_half),
   .cfg_cont    (cfg_cont),
   .tx_valid    (tx_valid),
   .fill_req    (fill_req),
   .tx_pop      (tx_pop),
   .rx_done     (rx_done),
   .sclk        (sclk),
   .ss_n        (ss_n),
   .slv_miso_o  (slv_miso_o),
   .slv_miso_oe (slv_miso_oe)
);

// File: tb/spi_shift_master_bench.sv
module spi_shift_master_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] sclk_half = 8'd1;
   logic       cfg_cont = 1'b0;
   logic       cfg_lsb_first = 1'b0;
   logic       cfg_zero_fill = 1'b0;
   logic       cfg_loopback = 1'b0;
   logic       cfg_miso_dis = 1'b0;
   logic       fill_req = 1'b0;
   logic       slv_bit = 1'b0;
   logic [7:0] tx_data;
   logic       tx_valid;
   logic       tx_pop;
   logic [7:0] rx_data;
   logic       rx_done;
   logic       sclk;
   logic       mosi;
   logic       ss_n;
   logic       miso;
   logic       slv_miso_o;
   logic       slv_miso_oe;

   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   // transmit source model
   logic [7:0] tx_q [16];
   int pop_cnt = 0;
   int tx_end = 0;
   assign tx_valid = (pop_cnt < tx_end);
   assign tx_data  = tx_q[pop_cnt & 15];
   always @(posedge clk) if (tx_pop) pop_cnt <= pop_cnt + 1;

   // slave model: always sends bit 7 of its byte first
   logic [7:0] sl_q [16];
   int sl_k = 0;
   int sl_bit = 0;
   assign miso = sl_q[sl_k & 15][7 - sl_bit];
   always @(negedge sclk) begin
      if (sl_bit == 7) begin
         sl_bit = 0;
         sl_k = sl_k + 1;
      end else begin
         sl_bit = sl_bit + 1;
      end
   end

   // MOSI capture: first bit goes to bit 7
   logic [7:0] cap [16];
   logic [7:0] m_sh = 8'h00;
   int m_bits = 0;
   int cap_n = 0;
   always @(posedge sclk) begin
      m_sh = {m_sh[6:0], mosi};
      m_bits = m_bits + 1;
      if (m_bits == 8) begin
         cap[cap_n & 15] = m_sh;
         cap_n = cap_n + 1;
         m_bits = 0;
      end
   end

   // received bytes, select edges, phase widths
   logic [7:0] rx_got [16];
   int rx_n = 0;
   int ss_rise = 0;
   int gaps [16];
   int g_n = 0;
   int gap_cnt = 0;
   int hi_cnt = 0;
   int last_hi = 0;
   int lo_cnt = 0;
   int last_lo = 0;
   always @(posedge ss_n) ss_rise = ss_rise + 1;
   always @(negedge clk) begin
      if (rx_done) begin
         rx_got[rx_n & 15] = rx_data;
         rx_n = rx_n + 1;
      end
      if (ss_n) gap_cnt = gap_cnt + 1;
      else if (gap_cnt != 0) begin
         gaps[g_n & 15] = gap_cnt;
         g_n = g_n + 1;
         gap_cnt = 0;
      end
      if (sclk) hi_cnt = hi_cnt + 1;
      else if (hi_cnt != 0) begin
         last_hi = hi_cnt;
         hi_cnt = 0;
      end
      if (!ss_n && !sclk) lo_cnt = lo_cnt + 1;
      else if (lo_cnt != 0) begin
         last_lo = lo_cnt;
         lo_cnt = 0;
      end
   end

   spi_shift_master u_spi_shift_master (
      .clk           (clk),
      .rst_n         (rst_n),
      .sclk_half     (sclk_half),
      .cfg_cont      (cfg_cont),
      .cfg_lsb_first (cfg_lsb_first),
      .cfg_zero_fill (cfg_zero_fill),
      .cfg_loopback  (cfg_loopback),
      .cfg_miso_dis  (cfg_miso_dis),
      .tx_data       (tx_data),
      .tx_valid      (tx_valid),
      .fill_req      (fill_req),
      .tx_pop        (tx_pop),
      .rx_data       (rx_data),
      .rx_done       (rx_done),
      .sclk          (sclk),
      .mosi          (mosi),
      .ss_n          (ss_n),
      .miso          (miso),
      .slv_bit       (slv_bit),
      .slv_miso_o    (slv_miso_o),
      .slv_miso_oe   (slv_miso_oe)
   );

   function automatic logic [7:0] rev8(input logic [7:0] v);
      logic [7:0] r;
      for (int i = 0; i < 8; i++) r[i] = v[7 - i];
      return r;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      total = total + 1;
      if (act !== exp) begin
         bad = bad + 1;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic push_tx(input logic [7:0] b);
      tx_q[tx_end & 15] = b;
      tx_end = tx_end + 1;
   endtask

   task automatic set_sl(input int ofs, input logic [7:0] b);
      sl_q[(sl_k + ofs) & 15] = b;
   endtask

   task automatic wait_done();
      @(negedge clk);
      while (tx_valid || fill_req || !ss_n) @(negedge clk);
      repeat (24) @(negedge clk);
   endtask

   task automatic t_reset();
      check("R1 ss_n", ss_n, 1);
      check("R1 sclk", sclk, 0);
      check("R1 rx_done", rx_done, 0);
      check("R1 tx_pop", tx_pop, 0);
   endtask

   task automatic fill_once(input logic zero);
      cfg_zero_fill = zero;
      fill_req = 1'b1;
      @(negedge clk);
      while (ss_n) @(negedge clk);
      fill_req = 1'b0;
      wait_done();
   endtask

   task automatic t_fill_after_reset();
      int c0 = cap_n;
      set_sl(0, 8'h11);
      fill_once(1'b0);
      check("R9 repeat fill after reset", cap[c0 & 15], 8'h00);
      check("R9 one fill byte", cap_n - c0, 1);
   endtask

   task automatic t_msb();
      int c0 = cap_n;
      int r0 = rx_n;
      sclk_half = 8'd1;
      cfg_lsb_first = 1'b0;
      set_sl(0, 8'h3C);
      push_tx(8'hA5);
      wait_done();
      check("R2 mosi msb first", cap[c0 & 15], 8'hA5);
      check("R2 rx msb first", rx_got[r0 & 15], 8'h3C);
      check("R5 one done pulse", rx_n - r0, 1);
      check("R4 high width", last_hi, 2);
      check("R5 one pop", pop_cnt, tx_end);
   endtask

   task automatic t_lsb();
      int c0 = cap_n;
      int r0 = rx_n;
      cfg_lsb_first = 1'b1;
      set_sl(0, 8'hC1);
      push_tx(8'h1E);
      wait_done();
      check("R3 mosi lsb first", cap[c0 & 15], rev8(8'h1E));
      check("R3 rx lsb first", rx_got[r0 & 15], rev8(8'hC1));
      cfg_lsb_first = 1'b0;
   endtask

   task automatic t_divider();
      int c0 = cap_n;
      int s0 = ss_rise;
      int g0 = g_n;
      sclk_half = 8'd3;
      set_sl(0, 8'h00);
      set_sl(1, 8'h00);
      push_tx(8'h81);
      push_tx(8'h7E);
      wait_done();
      check("R4 high width div3", last_hi, 4);
      check("R4 low width div3", last_lo, 4);
      check("R7 gap div3", gaps[(g0 + 1) & 15], 8);
      check("R7 rises div3", ss_rise - s0, 2);
      check("R2 second byte", cap[(c0 + 1) & 15], 8'h7E);
      sclk_half = 8'd1;
   endtask

   task automatic t_cont();
      int c0 = cap_n;
      int r0 = rx_n;
      int s0 = ss_rise;
      cfg_cont = 1'b1;
      set_sl(0, 8'h10);
      set_sl(1, 8'h20);
      set_sl(2, 8'h30);
      push_tx(8'hDE);
      push_tx(8'hAD);
      push_tx(8'h5A);
      wait_done();
      check("R6 single select rise", ss_rise - s0, 1);
      check("R6 bytes sent", cap_n - c0, 3);
      check("R6 third byte", cap[(c0 + 2) & 15], 8'h5A);
      check("R5 three done pulses", rx_n - r0, 3);
      check("R5 second rx", rx_got[(r0 + 1) & 15], 8'h20);
      check("R4 low width in burst", last_lo, 2);
      cfg_cont = 1'b0;
   endtask

   task automatic t_single();
      int c0 = cap_n;
      int s0 = ss_rise;
      int g0 = g_n;
      set_sl(0, 8'h01);
      set_sl(1, 8'h02);
      set_sl(2, 8'h03);
      push_tx(8'h12);
      push_tx(8'h34);
      push_tx(8'h56);
      wait_done();
      check("R7 three select rises", ss_rise - s0, 3);
      check("R7 gap one", gaps[(g0 + 1) & 15], 4);
      check("R7 gap two", gaps[(g0 + 2) & 15], 4);
      check("R7 last byte", cap[(c0 + 2) & 15], 8'h56);
   endtask

   task automatic t_fill();
      int c0;
      set_sl(0, 8'h00);
      push_tx(8'hC3);
      wait_done();
      c0 = cap_n;
      set_sl(0, 8'h00);
      fill_once(1'b0);
      check("R9 repeat last byte", cap[c0 & 15], 8'hC3);
      set_sl(0, 8'h00);
      fill_once(1'b1);
      check("R8 zero fill", cap[(c0 + 1) & 15], 8'h00);
      set_sl(0, 8'h00);
      fill_once(1'b0);
      check("R9 repeat after zero fill", cap[(c0 + 2) & 15], 8'h00);
      check("R8 fill count", cap_n - c0, 3);
   endtask

   task automatic t_loop();
      int r0 = rx_n;
      cfg_loopback = 1'b1;
      set_sl(0, 8'hFF);
      push_tx(8'h69);
      wait_done();
      check("R10 loopback rx", rx_got[r0 & 15], 8'h69);
      cfg_loopback = 1'b0;
   endtask

   task automatic t_slave_drv();
      cfg_miso_dis = 1'b0;
      slv_bit = 1'b1;
      #1;
      check("R11 enabled oe", slv_miso_oe, 1);
      check("R11 enabled data", slv_miso_o, 1);
      cfg_miso_dis = 1'b1;
      #1;
      check("R11 released oe", slv_miso_oe, 0);
      check("R11 released data", slv_miso_o, 0);
      cfg_miso_dis = 1'b0;
      slv_bit = 1'b0;
      #1;
      check("R11 follows bit", slv_miso_o, 0);
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            t_reset();
            rst_n = 1'b1;
            repeat (2) @(negedge clk);
            t_reset();
            t_fill_after_reset();
            t_msb();
            t_lsb();
            t_divider();
            t_cont();
            t_single();
            t_fill();
            t_loop();
            t_slave_drv();
         end
         begin
            repeat (150000) @(posedge clk);
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog actual=hung expected=finished");
         end
      join_any
      disable fork;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule